// File: doc/BRIEF.md
# Port Pin Edge Interrupt Controller

This block turns transitions on the pins of a general-purpose port into one interrupt request for the whole port. It receives pin levels that have already been synchronized to its clock, along with one function-select bit per pin. Each pin has a flag bit, an enable bit and an edge-select bit. A small register bus reads and writes these bits. When the selected edge appears on a pin, the hardware sets that pin's flag.

Software services the request by reading the flag register and writing 0 to the bits it has handled. It can also write 1 to a flag bit to raise an interrupt on purpose. The request stays asserted for as long as any enabled flag is set and the global interrupt enable input is high. A pin handed to another function through its function-select bit never sets its own flag.

Top module: `gpio_edge_irq`

## Requirements
- R1: After a synchronous active-low reset, the flag, edge-select and enable registers all read 0 and `irq` is 0. Holding the pins at any level during reset, or releasing reset, does not set a flag.
- R2: With edge-select bit 0, a low-to-high change on a pin sets its flag. The flag becomes readable at the first clock edge that samples the new level.
- R3: With edge-select bit 1, a high-to-low change on a pin sets its flag.
- R4: A pin held steady, whether high or low, never sets a flag, and neither does a change in the direction its edge-select bit does not choose.
- R5: `irq` is 1 exactly when some bit is 1 in both the flag and enable registers and `gie` is 1.
- R6: Writing the flag register loads it. A written 0 clears a flag and a written 1 sets it. With no write and no qualifying edge, every flag keeps its value.
- R7: A pin whose `func_sel` bit is 1 does not set its flag on any edge, whatever its enable bit holds.
- R8: Writing edge-select from 0 to 1 while the pin is low, or from 1 to 0 while it is high, sets the flag one clock after the write. The other two combinations leave the flag unchanged.
- R9: When a flag write and a qualifying edge on the same pin meet at the same clock edge, that pin's flag ends up 1.
- R10: Register offsets: 0 is the flags, 1 is edge-select, 2 is enable. Reads at any other offset return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | PINS | Synchronized pin levels |
| func_sel | input | PINS | 1 = pin serves another function; its interrupt is masked |
| gie | input | 1 | Global interrupt enable |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1 together with bus_sel |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data for bus_addr (combinational) |
| irq | output | 1 | Combined port interrupt request |

## Verification
The bench builds the block with its defaults: eight pins and a two-bit offset. Two offset bits are enough to reach the unmapped fourth offset, so that decode corner is tested. Eight pins are enough to run patterns where one pin's flag, edge-select or function-select differs from the others. With that setup the bench covers edge-select writes that set a flag, a flag write and a pin edge that collide, and the per-pin interaction between enable and `gie`.

// File: rtl/gpio_irq_pkg.sv
// Shared constants for the port edge interrupt controller.
// Assumes register offsets fit in the address width chosen by the top.
package gpio_irq_pkg;
    localparam int unsigned OFS_FLAG = 0;
    localparam int unsigned OFS_EDGE = 1;
    localparam int unsigned OFS_ENAB = 2;
endpackage

// File: rtl/gpio_edge_detect.sv
// Per-pin edge qualifier. The pin level is XORed with its edge-select bit, and a
// 0-to-1 change of that value produces a one-cycle event. Pins owned by another
// function are masked. Assumes pin levels are already synchronous to clk.
module gpio_edge_detect #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_lvl,
    input  logic [PINS-1:0] edge_sel,
    input  logic [PINS-1:0] mask,
    output logic [PINS-1:0] evt,
    output logic [PINS-1:0] prev_q
);
    logic [PINS-1:0] qual;

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        // Qualified level: high when the pin is at the level after its chosen edge
        assign qual[i] = pin_lvl[i] ^ edge_sel[i];

        // Remember last qualified level; reset loads the live level so reset cannot raise an event
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= pin_lvl[i];
            else        prev_q[i] <= qual[i];
        end

        // Event on a rising qualified level for pins not given to another function
        assign evt[i] = qual[i] & ~prev_q[i] & ~mask[i];
    end

    // R7
    masked_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt & mask) == '0);
endmodule

// File: rtl/gpio_irq_regs.sv
// Flag, edge-select and enable registers with a simple bus. Hardware events set
// flags and take priority over a software write in the same cycle. Assumes
// single-cycle writes and reads decoded from bus_addr alone.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    input  logic [PINS-1:0]   hw_evt,
    output logic [PINS-1:0]   flag_q,
    output logic [PINS-1:0]   edge_q,
    output logic [PINS-1:0]   enab_q,
    output logic [PINS-1:0]   rdata
);
    localparam logic [ADDR_W-1:0] A_FLAG = OFS_FLAG[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_EDGE = OFS_EDGE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_ENAB = OFS_ENAB[ADDR_W-1:0];

    logic wr;
    logic wr_flag, wr_edge, wr_enab;
    logic [PINS-1:0] flag_base;

    // Write strobes per register
    always_comb begin
        wr      = bus_sel & bus_we;
        wr_flag = wr && (bus_addr == A_FLAG);
        wr_edge = wr && (bus_addr == A_EDGE);
        wr_enab = wr && (bus_addr == A_ENAB);
    end

    // Software value for the flags before hardware events are merged in
    assign flag_base = wr_flag ? bus_wdata : flag_q;

    // Flag register: software load, then hardware set on top
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_base | hw_evt;
    end

    // Edge-select and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
            enab_q <= '0;
        end else begin
            if (wr_edge) edge_q <= bus_wdata;
            if (wr_enab) enab_q <= bus_wdata;
        end
    end

    // Read multiplexer; unmapped offsets read zero
    always_comb begin
        rdata = '0;
        if      (bus_addr == A_FLAG) rdata = flag_q;
        else if (bus_addr == A_EDGE) rdata = edge_q;
        else if (bus_addr == A_ENAB) rdata = enab_q;
    end

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_flag && hw_evt == '0) |=> $stable(flag_q));

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && hw_evt != '0) |=> ((flag_q & $past(hw_evt)) == $past(hw_evt)));
endmodule

// File: rtl/gpio_edge_irq.sv
// Top of the port edge interrupt controller: edge qualification, the register
// file and the combined request. Assumes pin_in and func_sel are synchronous to clk.
module gpio_edge_irq #(
    parameter int PINS   = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pin_in,
    input  logic [PINS-1:0]   func_sel,
    input  logic              gie,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    output logic              irq
);
    logic [PINS-1:0] evt, prev_q, flag_q, edge_q, enab_q;

    gpio_edge_detect #(.PINS(PINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_in), .edge_sel(edge_q),
        .mask(func_sel), .evt(evt), .prev_q(prev_q)
    );

    gpio_irq_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .hw_evt(evt),
        .flag_q(flag_q), .edge_q(edge_q), .enab_q(enab_q), .rdata(bus_rdata)
    );

    // Combined request for all pins of the port
    assign irq = gie & |(flag_q & enab_q);

    // R5
    irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie && flag_q != '0 && enab_q != '0));

    // R4
    steady_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_sel && bus_we) && ((pin_in ^ edge_q) == prev_q)) |=> $stable(flag_q));
endmodule

// File: tb/tb_gpio_edge_irq.sv
module tb_gpio_edge_irq;
    localparam int PINS = 8;
    localparam int AW   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PINS-1:0] pin_in = 8'hF0;
    logic [PINS-1:0] func_sel = '0;
    logic            gie = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [PINS-1:0] bus_wdata = '0;
    logic [PINS-1:0] bus_rdata;
    logic            irq;

    typedef struct {
        logic [PINS-1:0] exp_data;
        logic            exp_irq;
        string           tag;
    } item_t;

    item_t sbq[$];
    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_edge_irq #(.PINS(PINS), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .func_sel(func_sel), .gie(gie),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Monitor: compare queued expectations at the falling edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            vectors++;
            if (bus_rdata !== it.exp_data || irq !== it.exp_irq) begin
                miscompares++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         it.tag, bus_rdata, irq, it.exp_data, it.exp_irq);
            end
        end
    end

    task automatic chk(input logic [AW-1:0] a, input logic [PINS-1:0] d,
                       input logic i, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        sbq.push_back('{exp_data: d, exp_irq: i, tag: tag});
        wait (sbq.size() == 0);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [PINS-1:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic set_pin(input logic [PINS-1:0] v);
        @(posedge clk); #1;
        pin_in = v;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk(0, 8'h00, 0, "R1 flags after reset");
        chk(1, 8'h00, 0, "R1 edge-select after reset");
        chk(2, 8'h00, 0, "R1 enable after reset");
        chk(3, 8'h00, 0, "R10 unmapped offset reads zero");
        chk(0, 8'h00, 0, "R4 steady levels set nothing");

        wr(2, 8'hFF);
        gie = 1'b1;
        set_pin(8'hF1);
        chk(0, 8'h01, 1, "R2 rising edge sets flag, R5 irq");
        set_pin(8'hF0);
        chk(0, 8'h01, 1, "R4 falling edge with select 0 ignored");
        gie = 1'b0;
        chk(0, 8'h01, 0, "R5 gie low blocks irq");
        gie = 1'b1;
        wr(0, 8'h00);
        chk(0, 8'h00, 0, "R6 write 0 clears flag");

        wr(1, 8'h02);
        chk(0, 8'h02, 1, "R8 select 0->1 while low sets flag");
        wr(0, 8'h00);
        set_pin(8'hF2);
        chk(0, 8'h00, 0, "R4 rising edge with select 1 ignored");
        set_pin(8'hF0);
        chk(0, 8'h02, 1, "R3 falling edge with select 1 sets flag");
        wr(0, 8'h00);

        wr(1, 8'h12);
        chk(0, 8'h00, 0, "R8 select 0->1 while high unchanged");
        wr(1, 8'h02);
        chk(0, 8'h10, 1, "R8 select 1->0 while high sets flag");
        wr(0, 8'h00);

        func_sel = 8'h01;
        set_pin(8'hF1);
        chk(0, 8'h00, 0, "R7 function-selected pin masked");
        func_sel = 8'h00;
        set_pin(8'hF0);
        set_pin(8'hF1);
        chk(0, 8'h01, 1, "R7 unmasked pin sets again");
        wr(0, 8'h00);

        wr(0, 8'h80);
        chk(0, 8'h80, 1, "R6 write 1 sets flag");
        wr(2, 8'h01);
        chk(0, 8'h80, 0, "R5 flag without enable gives no irq");
        wr(2, 8'hFF);

        set_pin(8'hF0);
        wr(0, 8'h40);
        @(posedge clk); #1;
        pin_in = 8'hF1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 0; bus_wdata = 8'h00;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
        chk(0, 8'h01, 1, "R9 hardware set wins over clear");

        wr(3, 8'hFF);
        chk(0, 8'h01, 1, "R10 write to unmapped leaves flags");
        chk(1, 8'h02, 1, "R10 write to unmapped leaves edge-select");
        chk(2, 8'hFF, 1, "R10 write to unmapped leaves enable");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule